// File: doc/BRIEF.md
# Tagged memory controller

This block sits in front of a word-addressed data memory. It adds one hidden validity bit for each capability-sized, capability-aligned group of data words. The only way to set that bit is a capability store. Any ordinary data store that writes even one byte of the group clears the bit. A pointer that has been forged, or partly overwritten by plain data, therefore loses its validity.

Requests arrive on a valid/ready interface that accepts one request per cycle. The response follows exactly one cycle later. Addresses count data words. A capability spans `CAP_WORDS` consecutive data words, and the tag store costs one bit per capability: about 0.8 % of storage for 128-bit capabilities, or 0.4 % for 256-bit ones.

Capability loads return the whole group together with its tag, so the validity bit travels with the pointer into a register. Data loads never show the tag. Every access reads the addressed location before writing it, so a store's response carries the contents the location held before that store.

Top module: `tagmem_ctrl`

## Requirements
- R1: After reset every tag is 0, so a capability load of any word returns `rsp_rtag` = 0 before any capability store has been made.
- R2: A capability store (`req_op` = 2'b11) to an address whose low log2(CAP_WORDS) bits are zero writes every data word of the group from `req_wdata` and stores `req_wtag` as the group's tag. In `req_wdata`, lane k occupies bits [k*DATA_W +: DATA_W], and lane k is data word base+k. A later capability load (`req_op` = 2'b10) of the group returns that layout and that tag, with `rsp_err` = 0.
- R3: A data store (`req_op` = 2'b01) with at least one bit of `req_be` set writes only the enabled bytes of the addressed data word. Byte b is taken from `req_wdata` bits [b*8 +: 8]. The store also clears the tag of the group that holds the word. Other bytes, other words and other tags keep their values.
- R4: A data store with `req_be` all zero changes neither data nor any tag.
- R5: A data load (`req_op` = 2'b00) returns the addressed data word in `rsp_rdata` bits [DATA_W-1:0] with the upper bits zero. It returns `rsp_rtag` = 0 and `rsp_err` = 0 even when the group is tagged. Data operations never raise `rsp_err`.
- R6: A capability load or store whose address has a nonzero lane part gives `rsp_err` = 1, `rsp_rdata` = 0 and `rsp_rtag` = 0, and it changes no data and no tag.
- R7: `req_ready` is always 1. `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1, and 0 otherwise. When `rsp_valid` is 0, `rsp_rdata`, `rsp_rtag` and `rsp_err` are 0. A load issued in the cycle directly after a store to the same group sees the stored value.
- R8: A store's response returns the contents from before the write. A capability store returns the old group data and the old tag. A data store returns the old data word in the low bits, with the tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all tags |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; a request is taken on every valid cycle |
| req_op | input | 2 | 00 data load, 01 data store, 10 capability load, 11 capability store |
| req_addr | input | 5 | Data-word address (group index and lane) |
| req_be | input | 8 | Byte enables for a data store |
| req_wdata | input | 128 | Store data; a data store uses the low DATA_W bits |
| req_wtag | input | 1 | Tag written by a capability store |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 128 | Read data (old contents for stores) |
| rsp_rtag | output | 1 | Tag; nonzero only for capability accesses |
| rsp_err | output | 1 | Misaligned capability access |

## Verification
The hardest situation to reach from the ports is a narrow data store that lands on a group whose tag is already set. Only then does the clearing rule have a visible effect. To set this up, the bench re-arms each group with a tagged capability store before every data store. It then sweeps every data-word address against every byte-enable pattern, including the empty one, and reads the group back as a capability to confirm the tag and the merged bytes. A store followed on the very next cycle by a load of the same group tests that the written data is visible straight away, while the store's own response still shows the old contents.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    typedef enum logic [1:0] {
        OP_LD_DATA = 2'b00,
        OP_ST_DATA = 2'b01,
        OP_LD_CAP  = 2'b10,
        OP_ST_CAP  = 2'b11
    } tmc_op_e;

    // Decoded control for one accepted request.
    typedef struct packed {
        logic is_cap;    // capability-width access
        logic misalign;  // capability access not on a group boundary
        logic wr_data;   // data store that touches at least one byte
        logic wr_cap;    // aligned capability store
    } tmc_ctl_t;

    function automatic logic op_is_cap(input logic [1:0] op);
        return op[1];
    endfunction

    function automatic logic op_is_store(input logic [1:0] op);
        return op[0];
    endfunction

    function automatic tmc_ctl_t build_ctl(input logic valid, input logic [1:0] op,
                                           input logic lane_nonzero, input logic any_be);
        tmc_ctl_t c;
        c.is_cap   = op_is_cap(op);
        c.misalign = op_is_cap(op) && lane_nonzero;
        c.wr_data  = valid && !op_is_cap(op) && op_is_store(op) && any_be;
        c.wr_cap   = valid && op_is_cap(op) && op_is_store(op) && !lane_nonzero;
        return c;
    endfunction

endpackage

// File: rtl/tmc_req_decode.sv
module tmc_req_decode
    import tmc_pkg::*;
#(
    parameter  int ADDR_W = 5,
    parameter  int LANE_W = 1,
    parameter  int BE_W   = 8,
    localparam int IDX_W  = ADDR_W - LANE_W
) (
    input  logic              valid,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output tmc_ctl_t          ctl,
    output logic [IDX_W-1:0]  grp_idx,
    output logic [LANE_W-1:0] lane
);

    assign grp_idx = addr[ADDR_W-1:LANE_W];
    assign lane    = addr[LANE_W-1:0];

    always_comb begin
        ctl = build_ctl(valid, op, |addr[LANE_W-1:0], |be);
    end

endmodule

// File: rtl/tmc_data_banks.sv
module tmc_data_banks #(
    parameter  int DATA_W    = 64,
    parameter  int CAP_WORDS = 2,
    parameter  int CAP_DEPTH = 16,
    localparam int CAP_W     = DATA_W * CAP_WORDS,
    localparam int BE_W      = DATA_W / 8,
    localparam int LANE_W    = $clog2(CAP_WORDS),
    localparam int IDX_W     = $clog2(CAP_DEPTH)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic              wr_cap,
    input  logic              wr_data,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] lane,
    input  logic [BE_W-1:0]   be,
    input  logic [CAP_W-1:0]  wdata,
    output logic [CAP_W-1:0]  rd_line
);

    // One bank per lane, so a capability store writes all lanes in one cycle.
    for (genvar g = 0; g < CAP_WORDS; g++) begin : g_lane
        logic [DATA_W-1:0] bank [CAP_DEPTH];
        logic [DATA_W-1:0] rd_q;
        logic              lane_we;
        logic [BE_W-1:0]   lane_be;
        logic [DATA_W-1:0] lane_wd;

        assign lane_we = wr_cap || (wr_data && (lane == LANE_W'(g)));
        assign lane_be = wr_cap ? {BE_W{1'b1}} : be;
        assign lane_wd = wr_cap ? wdata[g*DATA_W +: DATA_W] : wdata[DATA_W-1:0];

        // Read-first: the read register takes the old contents.
        always_ff @(posedge clk) begin
            if (rd_en) begin
                rd_q <= bank[idx];
            end
            for (int b = 0; b < BE_W; b++) begin
                if (lane_we && lane_be[b]) begin
                    bank[idx][b*8 +: 8] <= lane_wd[b*8 +: 8];
                end
            end
        end

        assign rd_line[g*DATA_W +: DATA_W] = rd_q;
    end

endmodule

// File: rtl/tmc_tag_bits.sv
module tmc_tag_bits #(
    parameter  int CAP_DEPTH = 16,
    localparam int IDX_W     = $clog2(CAP_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] idx,
    output logic             rd_tag
);

    logic [CAP_DEPTH-1:0] tags;

    always_ff @(posedge clk) begin
        if (rst) begin
            tags   <= '0;
            rd_tag <= 1'b0;
        end else begin
            rd_tag <= tags[idx];
            if (wr_en) begin
                tags[idx] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
    import tmc_pkg::*;
#(
    parameter  int DATA_W    = 64,
    parameter  int CAP_WORDS = 2,
    parameter  int CAP_DEPTH = 16,
    localparam int CAP_W     = DATA_W * CAP_WORDS,
    localparam int BE_W      = DATA_W / 8,
    localparam int LANE_W    = $clog2(CAP_WORDS),
    localparam int IDX_W     = $clog2(CAP_DEPTH),
    localparam int ADDR_W    = IDX_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [CAP_W-1:0]  req_wdata,
    input  logic              req_wtag,
    output logic              rsp_valid,
    output logic [CAP_W-1:0]  rsp_rdata,
    output logic              rsp_rtag,
    output logic              rsp_err
);

    tmc_ctl_t          ctl;
    logic [IDX_W-1:0]  grp_idx;
    logic [LANE_W-1:0] lane;
    logic [CAP_W-1:0]  line;
    logic              tag_rd;

    logic              v_q;
    logic              cap_q;
    logic              mis_q;
    logic [LANE_W-1:0] lane_q;

    assign req_ready = 1'b1;

    tmc_req_decode #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .BE_W   (BE_W)
    ) u_dec (
        .valid   (req_valid),
        .op      (req_op),
        .addr    (req_addr),
        .be      (req_be),
        .ctl     (ctl),
        .grp_idx (grp_idx),
        .lane    (lane)
    );

    tmc_data_banks #(
        .DATA_W    (DATA_W),
        .CAP_WORDS (CAP_WORDS),
        .CAP_DEPTH (CAP_DEPTH)
    ) u_banks (
        .clk     (clk),
        .rd_en   (req_valid),
        .wr_cap  (ctl.wr_cap),
        .wr_data (ctl.wr_data),
        .idx     (grp_idx),
        .lane    (lane),
        .be      (req_be),
        .wdata   (req_wdata),
        .rd_line (line)
    );

    // Any touching data store writes 0; an aligned capability store writes its tag.
    tmc_tag_bits #(
        .CAP_DEPTH (CAP_DEPTH)
    ) u_tags (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctl.wr_cap || ctl.wr_data),
        .wr_val (ctl.wr_cap && req_wtag),
        .idx    (grp_idx),
        .rd_tag (tag_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= 1'b0;
            cap_q  <= 1'b0;
            mis_q  <= 1'b0;
            lane_q <= '0;
        end else begin
            v_q    <= req_valid;
            cap_q  <= ctl.is_cap;
            mis_q  <= ctl.misalign;
            lane_q <= lane;
        end
    end

    always_comb begin
        rsp_valid = v_q;
        rsp_rdata = '0;
        rsp_rtag  = 1'b0;
        rsp_err   = 1'b0;
        if (v_q) begin
            if (mis_q) begin
                rsp_err = 1'b1;
            end else if (cap_q) begin
                rsp_rdata = line;
                rsp_rtag  = tag_rd;
            end else begin
                rsp_rdata[DATA_W-1:0] = line[lane_q*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/tagmem_ctrl_chk.sv
module tagmem_ctrl_chk #(
    parameter  int DATA_W    = 64,
    parameter  int CAP_WORDS = 2,
    parameter  int CAP_DEPTH = 16,
    localparam int CAP_W     = DATA_W * CAP_WORDS,
    localparam int LANE_W    = $clog2(CAP_WORDS),
    localparam int ADDR_W    = $clog2(CAP_DEPTH) + LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [CAP_W-1:0]  rsp_rdata,
    input logic              rsp_rtag,
    input logic              rsp_err
);

    a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err && !rsp_rtag && rsp_rdata == '0));

    a_r6_misaligned_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1] && req_addr[LANE_W-1:0] != '0)
        |=> (rsp_err && !rsp_rtag && rsp_rdata == '0));

    a_r5_data_hides_tag: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op[1]) |=> (!rsp_rtag && !rsp_err && rsp_rdata[CAP_W-1:DATA_W] == '0));

    a_r2_aligned_no_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1] && req_addr[LANE_W-1:0] == '0) |=> !rsp_err);

endmodule

bind tagmem_ctrl tagmem_ctrl_chk #(
    .DATA_W    (DATA_W),
    .CAP_WORDS (CAP_WORDS),
    .CAP_DEPTH (CAP_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_rtag  (rsp_rtag),
    .rsp_err   (rsp_err)
);

// File: tb/tagmem_ctrl_test.sv
module tagmem_ctrl_test;

    localparam int DW   = 16;
    localparam int CW   = 2;
    localparam int CD   = 8;
    localparam int CAPW = DW * CW;
    localparam int BEW  = DW / 8;
    localparam int AW   = 4;
    localparam int NW   = CD * CW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_op = 2'b00;
    logic [AW-1:0]   req_addr = '0;
    logic [BEW-1:0]  req_be = '0;
    logic [CAPW-1:0] req_wdata = '0;
    logic            req_wtag = 1'b0;
    logic            rsp_valid;
    logic [CAPW-1:0] rsp_rdata;
    logic            rsp_rtag;
    logic            rsp_err;

    always #2.5 clk = ~clk;

    tagmem_ctrl #(.DATA_W(DW), .CAP_WORDS(CW), .CAP_DEPTH(CD)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_wtag(req_wtag), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_rtag(rsp_rtag), .rsp_err(rsp_err)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [DW-1:0] mem_m [NW];
    logic          tag_m [CD];

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int c, input int k, input int s);
        return DW'(16'h1357 * (c + 1) + 16'h0F11 * k + 16'h2468 * s);
    endfunction

    // Computes the expected response from the model, updates the model, then runs one request.
    task automatic xact(input logic [1:0] op, input int addr, input logic [BEW-1:0] be,
                        input logic [CAPW-1:0] wd, input logic wt, input string rq, input bit chk_data);
        logic [CAPW-1:0] ed;
        logic et, ee;
        int ci, base;
        bit mis;
        ci = addr / CW;
        base = ci * CW;
        mis = op[1] && (addr % CW != 0);
        ed = '0; et = 1'b0; ee = 1'b0;
        if (mis) begin
            ee = 1'b1;
        end else if (op[1]) begin
            ed = {mem_m[base+1], mem_m[base]};
            et = tag_m[ci];
        end else begin
            ed[DW-1:0] = mem_m[addr];
        end
        if (!mis) begin
            if (op == 2'b11) begin
                mem_m[base]   = wd[DW-1:0];
                mem_m[base+1] = wd[CAPW-1:DW];
                tag_m[ci]     = wt;
            end else if (op == 2'b01) begin
                for (int b = 0; b < BEW; b++) begin
                    if (be[b]) mem_m[addr][b*8 +: 8] = wd[b*8 +: 8];
                end
                if (be != '0) tag_m[ci] = 1'b0;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
        req_be = be; req_wdata = wd; req_wtag = wt;
        @(negedge clk);
        chk(rq, "rsp_valid", 64'(rsp_valid), 64'(1));
        chk(rq, "rsp_err", 64'(rsp_err), 64'(ee));
        chk(rq, "rsp_rtag", 64'(rsp_rtag), 64'(et));
        if (chk_data) chk(rq, "rsp_rdata", 64'(rsp_rdata), 64'(ed));
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R7: quiet outputs and ready after reset
        @(negedge clk);
        chk("R7", "reset rsp_valid", 64'(rsp_valid), 64'(0));
        chk("R7", "req_ready", 64'(req_ready), 64'(1));

        // R1: every tag clear after reset
        for (int c = 0; c < CD; c++) tag_m[c] = 1'b0;
        for (int c = 0; c < CD; c++) xact(2'b10, c * CW, '0, '0, 1'b0, "R1", 0);

        // R2: first fill with alternating tags, then read back
        for (int c = 0; c < CD; c++)
            xact(2'b11, c * CW, '0, {pat(c, 1, 0), pat(c, 0, 0)}, 1'(c), "R2", 0);
        for (int c = 0; c < CD; c++) xact(2'b10, c * CW, '0, '0, 1'b0, "R2", 1);

        // R8: second fill returns old contents and old tags
        for (int c = 0; c < CD; c++)
            xact(2'b11, c * CW, '0, {pat(c, 1, 1), pat(c, 0, 1)}, 1'b1, "R8", 1);

        // R5: data loads of tagged words hide the tag
        for (int a = 0; a < NW; a++) xact(2'b00, a, '0, '0, 1'b0, "R5", 1);

        // R6: misaligned capability store and load, then confirm nothing moved
        for (int c = 0; c < CD; c++) begin
            xact(2'b11, c * CW + 1, '0, 32'hDEAD_BEEF, 1'b0, "R6", 1);
            xact(2'b10, c * CW + 1, '0, '0, 1'b0, "R6", 1);
            xact(2'b10, c * CW, '0, '0, 1'b0, "R6", 1);
        end

        // R3 / R4: every word against every byte-enable pattern on a tagged group
        for (int a = 0; a < NW; a++) begin
            for (int be = 0; be < (1 << BEW); be++) begin
                xact(2'b11, (a / CW) * CW, '0, {pat(a, 1, be), pat(a, 0, be)}, 1'b1, "R2", 1);
                xact(2'b01, a, BEW'(be), CAPW'(16'hC3A5 ^ DW'(a * 37 + be)), 1'b0, "R8", 1);
                xact(2'b10, (a / CW) * CW, '0, '0, 1'b0, (be == 0) ? "R4" : "R3", 1);
            end
        end

        // R7: store then load of the same group on consecutive cycles
        begin
            logic [CAPW-1:0] oldv, newv;
            oldv = {mem_m[5], mem_m[4]};
            newv = 32'h5A5A_0F0F;
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'b11; req_addr = AW'(4); req_wdata = newv; req_wtag = 1'b1;
            @(negedge clk);
            chk("R8", "b2b store old data", 64'(rsp_rdata), 64'(oldv));
            req_op = 2'b10;
            @(negedge clk);
            chk("R7", "b2b load valid", 64'(rsp_valid), 64'(1));
            chk("R7", "b2b load data", 64'(rsp_rdata), 64'(newv));
            chk("R7", "b2b load tag", 64'(rsp_rtag), 64'(1));
            req_valid = 1'b0;
            @(negedge clk);
            chk("R7", "idle rsp_valid", 64'(rsp_valid), 64'(0));
            chk("R7", "idle rsp_rdata", 64'(rsp_rdata), 64'(0));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R7 watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule